// File: doc/BRIEF.md
# Charge-Pump Gain and Power-State Controller

This block decides how hard a multi-channel LED supply charge pump must work and when the whole output stage may sleep. It picks one of four voltage gains (1x, 1.33x, 1.5x, 2x) from two flags that the analog channels send up. One flag says that some active channel has lost regulation. The other says that unity gain would now be enough. A gain change needs its flag to be steady for a qualification window. Rising gain goes one step at a time. Falling gain always goes straight back to unity. An overvoltage flag drops the pump to unity at once.

A second state machine owns the power state. It has four states. RUN is normal operation. HOT is thermal shutdown. SLEEP is low power. WAKE is the ready delay after a bus wake-up. A hot die forces HOT from any state: the pump and the LEDs turn off and status bit D0 is raised. Operation resumes by itself once the die cools. When no channel is enabled and the serial bus has been quiet for the idle window, the controller enters SLEEP, which turns the pump off and raises status bit D2. Configuration registers elsewhere are not touched. Bus activity in SLEEP starts WAKE. D2 stays high until the ready counter expires, and then the block returns to RUN with the gain at unity.

Power-state transitions:
- RUN→SLEEP when the idle count expires.
- SLEEP→WAKE on bus activity.
- WAKE→RUN when the ready count expires.
- any state→HOT while over-temperature is flagged.
- HOT→RUN once it clears.

Gain transitions:
- Step up: 1X→1P33→1P5→2X after a qualified shortfall.
- Drop: any boosted state→1X after a qualified "unity suffices".
- Overvoltage: any boosted state→1X immediately.
- Hold: the gain is forced to 1X in any power state other than RUN.

Top module: `cp_pwr_ctrl`

## Requirements
- R1: After reset the gain code is 00 (1x), pump and LED enables are 1, and both status bits D0 and D2 are 0.
- R2: Gain codes are 00=1x, 01=1.33x, 10=1.5x, 11=2x. While the shortfall flag is held in RUN, the code rises by exactly one step after every QUAL_CYC consecutive qualifying cycles. The code changes on the QUAL_CYC-th clock edge.
- R3: At code 11 the gain stays at 11 while the shortfall flag persists.
- R4: From any boosted code, QUAL_CYC consecutive cycles of "unity suffices" return the code directly to 00. That flag takes priority over the shortfall flag.
- R5: Overvoltage in a boosted code sets the code to 00 on the next edge, without qualification. In code 00 it has no effect, and an upward qualification in progress still completes.
- R6: A qualifying condition that drops for one cycle restarts its count. Every gain change restarts all counts.
- R7: Over-temperature sets D0 and clears the pump and LED enables on the next edge, from any state. The gain is 00 one edge later. The edge after the flag clears returns to RUN with D0=0.
- R8: IDLE_CYC consecutive cycles in RUN with an all-zero enable mask and no bus activity enter SLEEP: D2=1, pump and LED enables 0, gain 00.
- R9: Bus activity in SLEEP starts the wake delay. D2 stays 1 and the pump is enabled while the LEDs remain off. After WAKE_CYC edges in WAKE, D2 drops to 0 and the LEDs come back on, with the gain starting from 00.
- R10: A nonzero enable mask, or any bus activity pulse, restarts the idle count. Activity more often than every IDLE_CYC cycles therefore keeps D2 at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_short_i | input | 1 | Some active channel lacks regulation headroom |
| one_x_ok_i | input | 1 | Unity gain would regulate all active channels |
| over_volt_i | input | 1 | Pump output overvoltage |
| over_temp_i | input | 1 | Die over-temperature |
| en_mask_i | input | NCH | Channel enable mask |
| bus_act_i | input | 1 | One-cycle pulse on serial bus activity |
| pump_mode_o | output | 2 | Gain code (00/01/10/11) |
| pump_en_o | output | 1 | Charge pump enable |
| led_en_o | output | 1 | Global LED output enable |
| stat_ot_o | output | 1 | Status D0, over-temperature |
| stat_lp_o | output | 1 | Status D2, low power |

## Verification
A corrupted qualification count shows up as a gain step that lands one or more edges early or late. A corrupted power state shows up at once as a wrong combination of pump enable, LED enable, D0 and D2. The bench runs a behavioural model beside the design and compares all five outputs on every cycle. A fault is therefore seen in the cycle it first reaches the ports, rather than at the end of a phase. Directed checks also pin the exact edge of each gain step, the idle entry, and the release of the wake delay.

// File: rtl/cp_pwr_pkg.sv
package cp_pwr_pkg;

    typedef enum logic [1:0] {
        GAIN_1X  = 2'b00,
        GAIN_1P33 = 2'b01,
        GAIN_1P5 = 2'b10,
        GAIN_2X  = 2'b11
    } gain_e;

    typedef enum logic [1:0] {
        PW_RUN   = 2'b00,
        PW_HOT   = 2'b01,
        PW_SLEEP = 2'b10,
        PW_WAKE  = 2'b11
    } pwr_e;

endpackage

// File: rtl/cp_span_cnt.sv
module cp_span_cnt #(
    parameter int unsigned LIMIT = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic run,
    output logic done
);
    localparam int unsigned W = (LIMIT > 1) ? $clog2(LIMIT) : 1;
    localparam logic [W-1:0] LAST = W'(LIMIT - 1);

    logic [W-1:0] cnt_q;

    // done on the LIMIT-th consecutive cycle of run
    assign done = run && (cnt_q == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr || !run || done) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/cp_gain_fsm.sv
module cp_gain_fsm
    import cp_pwr_pkg::*;
#(
    parameter int unsigned QUAL_CYC = 64
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  hold,
    input  logic  reg_short,
    input  logic  one_x_ok,
    input  logic  over_volt,
    output gain_e mode
);
    gain_e mode_q, mode_d;
    logic  dn_req, up_req, dn_done, up_done, chg;

    // unity-suffices outranks shortfall
    assign dn_req = one_x_ok && (mode_q != GAIN_1X) && !hold;
    assign up_req = reg_short && (mode_q != GAIN_2X) && !hold && !dn_req;

    cp_span_cnt #(.LIMIT(QUAL_CYC)) u_dn_qual (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (chg),
        .run   (dn_req),
        .done  (dn_done)
    );

    cp_span_cnt #(.LIMIT(QUAL_CYC)) u_up_qual (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (chg),
        .run   (up_req),
        .done  (up_done)
    );

    always_comb begin
        mode_d = mode_q;
        if (hold) begin
            mode_d = GAIN_1X;
        end else if (over_volt && (mode_q != GAIN_1X)) begin
            mode_d = GAIN_1X;
        end else if (dn_done) begin
            mode_d = GAIN_1X;
        end else if (up_done) begin
            unique case (mode_q)
                GAIN_1X:   mode_d = GAIN_1P33;
                GAIN_1P33: mode_d = GAIN_1P5;
                GAIN_1P5:  mode_d = GAIN_2X;
                GAIN_2X:   mode_d = GAIN_2X;
            endcase
        end
    end

    assign chg = (mode_d != mode_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= GAIN_1X;
        end else begin
            mode_q <= mode_d;
        end
    end

    assign mode = mode_q;

    AST_GAIN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (mode_q == GAIN_1X) || (2'(mode_q) == 2'($past(mode_q)))
                 || (2'(mode_q) == 2'($past(mode_q)) + 2'd1)); // R2

    AST_TOP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == GAIN_2X) && reg_short && !one_x_ok && !over_volt && !hold
        |=> (mode_q == GAIN_2X)); // R3

    AST_OV_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        over_volt && !hold && (mode_q != GAIN_1X) |=> (mode_q == GAIN_1X)); // R5

    AST_HOLD_UNITY: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> (mode_q == GAIN_1X)); // R9

endmodule

// File: rtl/cp_pwr_fsm.sv
module cp_pwr_fsm
    import cp_pwr_pkg::*;
#(
    parameter int unsigned IDLE_CYC = 500000,
    parameter int unsigned WAKE_CYC = 50000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic over_temp,
    input  logic quiet,
    input  logic bus_act,
    output logic pump_en,
    output logic led_en,
    output logic stat_ot,
    output logic stat_lp,
    output logic hold
);
    pwr_e st_q, st_d;
    logic idle_done, wake_done;

    cp_span_cnt #(.LIMIT(IDLE_CYC)) u_idle (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (1'b0),
        .run   ((st_q == PW_RUN) && quiet),
        .done  (idle_done)
    );

    cp_span_cnt #(.LIMIT(WAKE_CYC)) u_wake (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (1'b0),
        .run   (st_q == PW_WAKE),
        .done  (wake_done)
    );

    always_comb begin
        st_d = st_q;
        if (over_temp) begin
            st_d = PW_HOT;
        end else begin
            unique case (st_q)
                PW_RUN:   if (idle_done) st_d = PW_SLEEP;
                PW_HOT:   st_d = PW_RUN;
                PW_SLEEP: if (bus_act) st_d = PW_WAKE;
                PW_WAKE:  if (wake_done) st_d = PW_RUN;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= PW_RUN;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        pump_en = 1'b0;
        led_en  = 1'b0;
        stat_ot = 1'b0;
        stat_lp = 1'b0;
        unique case (st_q)
            PW_RUN: begin
                pump_en = 1'b1;
                led_en  = 1'b1;
            end
            PW_HOT: begin
                stat_ot = 1'b1;
            end
            PW_SLEEP: begin
                stat_lp = 1'b1;
            end
            PW_WAKE: begin
                pump_en = 1'b1;
                stat_lp = 1'b1;
            end
        endcase
    end

    assign hold = (st_q != PW_RUN);

    AST_HOT_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        over_temp |=> stat_ot && !pump_en && !led_en); // R7

    AST_SLEEP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stat_lp) |-> $past(quiet)); // R8

    AST_READY_LATE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(stat_lp) && !stat_ot |-> ($past(st_q) == PW_WAKE)); // R9

endmodule

// File: rtl/cp_pwr_ctrl.sv
module cp_pwr_ctrl
    import cp_pwr_pkg::*;
#(
    parameter int unsigned NCH      = 8,
    parameter int unsigned QUAL_CYC = 64,
    parameter int unsigned IDLE_CYC = 500000,
    parameter int unsigned WAKE_CYC = 50000
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           reg_short_i,
    input  logic           one_x_ok_i,
    input  logic           over_volt_i,
    input  logic           over_temp_i,
    input  logic [NCH-1:0] en_mask_i,
    input  logic           bus_act_i,
    output logic [1:0]     pump_mode_o,
    output logic           pump_en_o,
    output logic           led_en_o,
    output logic           stat_ot_o,
    output logic           stat_lp_o
);
    logic  quiet, hold;
    gain_e mode;

    assign quiet = (en_mask_i == '0) && !bus_act_i;

    cp_pwr_fsm #(
        .IDLE_CYC (IDLE_CYC),
        .WAKE_CYC (WAKE_CYC)
    ) u_pwr (
        .clk       (clk),
        .rst_n     (rst_n),
        .over_temp (over_temp_i),
        .quiet     (quiet),
        .bus_act   (bus_act_i),
        .pump_en   (pump_en_o),
        .led_en    (led_en_o),
        .stat_ot   (stat_ot_o),
        .stat_lp   (stat_lp_o),
        .hold      (hold)
    );

    cp_gain_fsm #(
        .QUAL_CYC (QUAL_CYC)
    ) u_gain (
        .clk       (clk),
        .rst_n     (rst_n),
        .hold      (hold),
        .reg_short (reg_short_i),
        .one_x_ok  (one_x_ok_i),
        .over_volt (over_volt_i),
        .mode      (mode)
    );

    assign pump_mode_o = mode;

endmodule

// File: tb/cp_pwr_ctrl_test.sv
module cp_pwr_ctrl_test;
    localparam int NCH = 8;
    localparam int Q   = 4;
    localparam int IDL = 40;
    localparam int WK  = 10;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           rs = 1'b0, ok = 1'b0, ov = 1'b0, ot = 1'b0, ba = 1'b0;
    logic [NCH-1:0] mask = 8'h01;
    logic [1:0]     mode_o;
    logic           pump_o, led_o, d0_o, d2_o;

    int    checks = 0;
    int    errors = 0;
    string tag = "R1";
    bit    finished = 1'b0;

    always #5 clk = ~clk;

    cp_pwr_ctrl #(.NCH(NCH), .QUAL_CYC(Q), .IDLE_CYC(IDL), .WAKE_CYC(WK)) uut (
        .clk(clk), .rst_n(rst_n), .reg_short_i(rs), .one_x_ok_i(ok),
        .over_volt_i(ov), .over_temp_i(ot), .en_mask_i(mask), .bus_act_i(ba),
        .pump_mode_o(mode_o), .pump_en_o(pump_o), .led_en_o(led_o),
        .stat_ot_o(d0_o), .stat_lp_o(d2_o)
    );

    // behavioural reference: 0 run, 1 hot, 2 sleep, 3 wake
    int m_p, m_mode, m_ic, m_wc, m_uc, m_dc;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_p = 0; m_mode = 0; m_ic = 0; m_wc = 0; m_uc = 0; m_dc = 0;
        end else begin
            int  np, nm;
            bit  dreq, ureq, dfire, ufire, idle_fire, wake_fire, q;
            // gain, seen from the present power state
            if (m_p != 0) begin
                m_mode = 0; m_uc = 0; m_dc = 0;
            end else begin
                dreq = ok && (m_mode != 0);
                ureq = rs && (m_mode != 3) && !dreq;
                m_dc = dreq ? m_dc + 1 : 0;
                m_uc = ureq ? m_uc + 1 : 0;
                dfire = (m_dc == Q);
                ufire = (m_uc == Q);
                if (dfire) m_dc = 0;
                if (ufire) m_uc = 0;
                nm = m_mode;
                if (ov && m_mode != 0) nm = 0;
                else if (dfire) nm = 0;
                else if (ufire) nm = m_mode + 1;
                if (nm != m_mode) begin m_uc = 0; m_dc = 0; end
                m_mode = nm;
            end
            // power state
            q = (mask == 0) && !ba;
            idle_fire = 1'b0;
            wake_fire = 1'b0;
            if (m_p == 0 && q) begin
                m_ic++;
                if (m_ic == IDL) begin idle_fire = 1'b1; m_ic = 0; end
            end else m_ic = 0;
            if (m_p == 3) begin
                m_wc++;
                if (m_wc == WK) begin wake_fire = 1'b1; m_wc = 0; end
            end else m_wc = 0;
            np = m_p;
            if (ot) np = 1;
            else if (m_p == 0 && idle_fire) np = 2;
            else if (m_p == 1) np = 0;
            else if (m_p == 2 && ba) np = 3;
            else if (m_p == 3 && wake_fire) np = 0;
            m_p = np;
        end
    end

    task automatic chk(input string t, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s act=%0h exp=%0h at %0t", t, act, exp, $time);
        end
    endtask

    function automatic int packed_out();
        return {26'd0, mode_o, pump_o, led_o, d0_o, d2_o};
    endfunction

    function automatic int model_out();
        int pe, le, h, s;
        pe = (m_p == 0 || m_p == 3) ? 1 : 0;
        le = (m_p == 0) ? 1 : 0;
        h  = (m_p == 1) ? 1 : 0;
        s  = (m_p == 2 || m_p == 3) ? 1 : 0;
        return (m_mode << 4) | (pe << 3) | (le << 2) | (h << 1) | s;
    endfunction

    // every-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && !finished) chk({tag, " model"}, packed_out(), model_out());
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : stim
        step(3);
        rst_n = 1'b1;
        step(1);
        // R1 reset state
        tag = "R1";
        chk("R1 mode", mode_o, 0);
        chk("R1 enables", {pump_o, led_o}, 2'b11);
        chk("R1 status", {d0_o, d2_o}, 2'b00);

        // R2 step-up sequence, R3 hold at top
        tag = "R2";
        rs = 1'b1;
        step(Q - 1);
        chk("R2 early", mode_o, 0);
        step(1);
        chk("R2 to 01", mode_o, 1);
        step(Q);
        chk("R2 to 10", mode_o, 2);
        step(Q);
        chk("R2 to 11", mode_o, 3);
        tag = "R3";
        step(3 * Q);
        chk("R3 hold 11", mode_o, 3);

        // R6 interrupted unity-suffices restarts; R4 direct drop
        tag = "R6";
        ok = 1'b1;
        step(Q - 1);
        ok = 1'b0;
        step(1);
        ok = 1'b1;
        step(Q - 1);
        chk("R6 restart", mode_o, 3);
        tag = "R4";
        step(1);
        chk("R4 direct drop", mode_o, 0);
        ok = 1'b0; rs = 1'b0;
        step(2);

        // R5 overvoltage
        tag = "R5";
        rs = 1'b1;
        step(Q);
        chk("R5 pre", mode_o, 1);
        ov = 1'b1;
        step(1);
        chk("R5 drop", mode_o, 0);
        step(Q);
        chk("R5 ignored at 1x", mode_o, 1);
        step(1);
        chk("R5 drop again", mode_o, 0);
        ov = 1'b0;
        step(Q);
        chk("R6 fresh count after change", mode_o, 1);
        rs = 1'b0;
        step(2);

        // R7 over-temperature
        tag = "R7";
        ot = 1'b1;
        step(1);
        chk("R7 off", {pump_o, led_o, d0_o}, 3'b001);
        chk("R7 mode lag", mode_o, 1);
        step(1);
        chk("R7 unity", mode_o, 0);
        step(5);
        ot = 1'b0;
        step(1);
        chk("R7 resume", {pump_o, led_o, d0_o}, 3'b110);

        // R10 activity keeps awake
        tag = "R10";
        mask = '0;
        for (int k = 0; k < 6; k++) begin
            step(IDL - 5);
            ba = 1'b1;
            step(1);
            ba = 1'b0;
        end
        chk("R10 awake", d2_o, 0);
        mask = 8'h80;
        step(IDL + 5);
        chk("R10 mask awake", d2_o, 0);

        // R8 idle entry (bus_act pulse just cleared the count)
        tag = "R8";
        mask = '0;
        ba = 1'b1;
        step(1);
        ba = 1'b0;
        rs = 1'b1;
        step(IDL - 1);
        chk("R8 not yet", d2_o, 0);
        step(1);
        chk("R8 asleep", {d2_o, pump_o, led_o}, 3'b100);
        step(2 * Q);
        chk("R8 unity", mode_o, 0);

        // R9 wake
        tag = "R9";
        ba = 1'b1;
        step(1);
        ba = 1'b0;
        chk("R9 waking", {d2_o, pump_o, led_o}, 3'b110);
        step(WK - 1);
        chk("R9 still low power", d2_o, 1);
        chk("R9 unity in wake", mode_o, 0);
        step(1);
        chk("R9 ready", {d2_o, led_o}, 2'b01);
        mask = 8'h01;
        step(Q);
        chk("R9 climbs from 00", mode_o, 1);
        rs = 1'b0;

        // R7 over-temperature while asleep
        tag = "R7";
        mask = '0;
        step(IDL + 2);
        chk("R8 asleep again", d2_o, 1);
        ot = 1'b1;
        step(1);
        chk("R7 from sleep", {d0_o, d2_o}, 2'b10);
        ot = 1'b0;
        step(1);
        chk("R7 back to run", {d0_o, d2_o, led_o}, 3'b001);
        mask = 8'h01;
        step(3);

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule